// File: doc/BRIEF.md
# Ping-Pong Correction Table Refill Controller

This block owns a table of 256 defect-pixel records. The table is split into a lower half (entries 0 to 127) and an upper half (entries 128 to 255). A pixel-side consumer sees the record at the current read index. It moves on by pulsing an advance strobe. The read index runs as a ring across both halves. When the consumer finishes a half, the block pulses a renew interrupt for that half. The host can then rewrite that half while the other half is still in use, so a defect list longer than the table can be streamed through it.

After reset, and again when the host asks for a restart, the block pulses an initialise interrupt and enters an initialise state. In that state the read index is held at zero. The table is reported ready only once both halves have been loaded. A half counts as loaded when the host writes its last entry. If the consumer advances over an entry in a half that has not been refilled since it was flagged, a sticky underrun flag is raised. Only the host can clear that flag. A frame-start input rewinds the read index to the start of the table.

Top module: `corr_table_pingpong`

## Requirements
- R1: `rdData` always shows the stored record at `rdIdx`. A host write (`hostWrEn`, `hostWrAddr`, `hostWrData`) updates that record from the next cycle on.
- R2: When the table is ready, a high `advance` moves `rdIdx` up by one on the next cycle. Index 255 wraps to 0.
- R3: An accepted advance while `rdIdx` is 127 gives a one-cycle `irqRenewLo` pulse on the next cycle and marks the lower half stale.
- R4: An accepted advance while `rdIdx` is 255 gives a one-cycle `irqRenewHi` pulse on the next cycle and marks the upper half stale.
- R5: A stale half becomes fresh when the host writes its last entry (127 for lower, 255 for upper). Writes to any other entry leave it stale. If that write falls in the same cycle as an advance that marks the same half stale, the half ends up stale.
- R6: `irqInit` pulses for one cycle on the first clock after reset is released. It also pulses on the cycle after `hostRestart`. A restart marks both halves stale, enters the initialise state and sets `rdIdx` to 0.
- R7: In the initialise state `tableReady` is 0, `rdIdx` stays 0, and `advance` and `frameStart` have no effect. The state ends, and `tableReady` rises, on the cycle after neither half is stale.
- R8: An accepted advance on an entry whose half is stale sets `underrunErr` on the next cycle. The flag stays set until `hostErrClr` is high. A new underrun in the same cycle as `hostErrClr` leaves the flag set.
- R9: `frameStart` while the table is ready sets `rdIdx` to 0 on the next cycle, overriding a simultaneous `advance`. The renew and underrun effects of that advance still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrAddr | input | 8 | Host write entry index |
| hostWrData | input | 24 | Host write record |
| hostRestart | input | 1 | Host request to restart initialisation |
| hostErrClr | input | 1 | Host clear of the underrun flag |
| frameStart | input | 1 | Frame start, rewinds the read index |
| advance | input | 1 | Consumer has used the current entry |
| rdIdx | output | 8 | Current read entry index |
| rdData | output | 24 | Record at the current read index |
| tableReady | output | 1 | Initialisation complete |
| irqInit | output | 1 | Initialise request pulse |
| irqRenewLo | output | 1 | Lower-half renew pulse |
| irqRenewHi | output | 1 | Upper-half renew pulse |
| underrunErr | output | 1 | Sticky underrun flag |

## Verification
Two things can land on one half in the same cycle: the consumer marks it stale by passing its last entry, and the host marks it fresh by writing that same entry. The bench drives both in one cycle at index 127. It then wraps the consumer back into the lower half and expects an underrun, because the stale mark must win. A clear of the underrun flag is also timed against a fresh underrun. A random phase keeps producing both collisions, and every cycle is compared with a behavioural reference.

// File: rtl/corr_table_pkg.sv
package corr_table_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic wrEn;    // store host record
    logic ptrInc;  // step the read pointer
    logic ptrClr;  // rewind the read pointer to entry 0
  } tblStrobe_t;

endpackage

// File: rtl/corr_table_dp.sv
module corr_table_dp
  import corr_table_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] tableMem [DEPTH];
  logic [IDX_W-1:0]  readPtr;

  // Record storage, no reset on the array
  always_ff @(posedge clk) begin
    if (strobe.wrEn) tableMem[wrAddr] <= wrData;
  end

  // Ring read pointer; clear has priority over increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPtr <= '0;
    end else if (strobe.ptrClr) begin
      readPtr <= '0;
    end else if (strobe.ptrInc) begin
      readPtr <= readPtr + 1'b1;
    end
  end

  assign rdIdx  = readPtr;
  assign rdData = tableMem[readPtr];

endmodule

// File: rtl/corr_table_ctrl.sv
module corr_table_ctrl
  import corr_table_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic             frameStart,
  input  logic             hostRestart,
  input  logic             hostErrClr,
  input  logic             hostWrEn,
  input  logic [IDX_W-1:0] hostWrAddr,
  input  logic [IDX_W-1:0] rdIdx,
  output tblStrobe_t       strobe,
  output logic             tableReady,
  output logic             irqInit,
  output logic [1:0]       irqRenew,
  output logic             underrunErr
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int HALF   = DEPTH / 2;
  localparam int NHALF  = 2;

  logic [NHALF-1:0] stale;
  logic [NHALF-1:0] staleNext;
  logic [NHALF-1:0] consumeEnd;
  logic             initMode;
  logic             initModeNext;
  logic             kickPending;
  logic             accept;
  logic             curHalfStale;
  logic             underrunNext;

  assign accept       = advance && !initMode;
  assign curHalfStale = stale[rdIdx[IDX_W-1]];

  // Per-half bookkeeping: consumption of the last entry flags the half,
  // a host write of the last entry refreshes it; flagging wins.
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam logic [IDX_W-1:0] END_IDX = IDX_W'((h + 1) * HALF - 1);
    logic refillEnd;
    assign consumeEnd[h] = accept && (rdIdx == END_IDX);
    assign refillEnd     = hostWrEn && (hostWrAddr == END_IDX);
    always_comb begin
      if (hostRestart)        staleNext[h] = 1'b1;
      else if (consumeEnd[h]) staleNext[h] = 1'b1;
      else if (refillEnd)     staleNext[h] = 1'b0;
      else                    staleNext[h] = stale[h];
    end
  end

  always_comb begin
    if (hostRestart)                      initModeNext = 1'b1;
    else if (initMode && (staleNext == '0)) initModeNext = 1'b0;
    else                                  initModeNext = initMode;
  end

  always_comb begin
    if (accept && curHalfStale) underrunNext = 1'b1;
    else if (hostErrClr)        underrunNext = 1'b0;
    else                        underrunNext = underrunErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stale       <= '1;
      initMode    <= 1'b1;
      kickPending <= 1'b1;
      irqInit     <= 1'b0;
      irqRenew    <= '0;
      underrunErr <= 1'b0;
    end else begin
      stale       <= staleNext;
      initMode    <= initModeNext;
      kickPending <= 1'b0;
      irqInit     <= kickPending || hostRestart;
      irqRenew    <= consumeEnd;
      underrunErr <= underrunNext;
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.wrEn   = hostWrEn;
    strobe.ptrInc = accept;
    strobe.ptrClr = hostRestart || (frameStart && !initMode);
  end

  assign tableReady = !initMode;

endmodule

// File: rtl/corr_table_pingpong.sv
module corr_table_pingpong
  import corr_table_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [IDX_W-1:0]  hostWrAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRestart,
  input  logic              hostErrClr,
  input  logic              frameStart,
  input  logic              advance,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              tableReady,
  output logic              irqInit,
  output logic              irqRenewLo,
  output logic              irqRenewHi,
  output logic              underrunErr
);

  tblStrobe_t strobe;
  logic [1:0] irqRenew;

  corr_table_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .advance(advance), .frameStart(frameStart),
    .hostRestart(hostRestart), .hostErrClr(hostErrClr),
    .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr), .rdIdx(rdIdx),
    .strobe(strobe), .tableReady(tableReady), .irqInit(irqInit),
    .irqRenew(irqRenew), .underrunErr(underrunErr)
  );

  corr_table_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(hostWrAddr),
    .wrData(hostWrData), .rdIdx(rdIdx), .rdData(rdData)
  );

  assign irqRenewLo = irqRenew[0];
  assign irqRenewHi = irqRenew[1];

endmodule

// File: rtl/corr_table_pingpong_chk.sv
module corr_table_pingpong_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             advance,
  input logic             frameStart,
  input logic             hostRestart,
  input logic             hostErrClr,
  input logic [IDX_W-1:0] rdIdx,
  input logic             tableReady,
  input logic             irqInit,
  input logic             irqRenewLo,
  input logic             irqRenewHi,
  input logic             underrunErr
);

  localparam logic [IDX_W-1:0] LO_END = IDX_W'((1 << IDX_W) / 2 - 1);
  localparam logic [IDX_W-1:0] HI_END = IDX_W'((1 << IDX_W) - 1);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && tableReady && !frameStart && !hostRestart)
      |=> (rdIdx == IDX_W'($past(rdIdx) + 1'b1)));

  // R3
  renew_lo_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqRenewLo |-> ($past(advance) && $past(tableReady) && ($past(rdIdx) == LO_END)));

  // R3
  renew_lo_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqRenewLo |=> !irqRenewLo);

  // R4
  renew_hi_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqRenewHi |-> ($past(advance) && $past(tableReady) && ($past(rdIdx) == HI_END)));

  // R4
  renew_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqRenewLo, irqRenewHi}));

  // R6
  init_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqInit |-> !tableReady);

  // R7
  init_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tableReady |-> (rdIdx == '0));

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrunErr && !hostErrClr) |=> underrunErr);

endmodule

bind corr_table_pingpong corr_table_pingpong_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .advance(advance), .frameStart(frameStart),
  .hostRestart(hostRestart), .hostErrClr(hostErrClr), .rdIdx(rdIdx),
  .tableReady(tableReady), .irqInit(irqInit), .irqRenewLo(irqRenewLo),
  .irqRenewHi(irqRenewHi), .underrunErr(underrunErr)
);

// File: tb/test_corr_table_pingpong.sv
`timescale 1ns/1ps
module test_corr_table_pingpong;
  localparam int DW = 24;
  localparam int IW = 8;
  localparam int N  = 256;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRestart = 1'b0, hostErrClr = 1'b0;
  logic frameStart = 1'b0, advance = 1'b0;
  logic [IW-1:0] hostWrAddr = '0;
  logic [DW-1:0] hostWrData = '0;
  logic [IW-1:0] rdIdx;
  logic [DW-1:0] rdData;
  logic tableReady, irqInit, irqRenewLo, irqRenewHi, underrunErr;

  corr_table_pingpong i_corr_table_pingpong (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr),
    .hostWrData(hostWrData), .hostRestart(hostRestart), .hostErrClr(hostErrClr),
    .frameStart(frameStart), .advance(advance), .rdIdx(rdIdx), .rdData(rdData),
    .tableReady(tableReady), .irqInit(irqInit), .irqRenewLo(irqRenewLo),
    .irqRenewHi(irqRenewHi), .underrunErr(underrunErr)
  );

  // Behavioural reference state
  int          mPtr;
  bit          mStale [2];
  bit          mInit, mKick, mErr, mIrqI, mIrqL, mIrqH;
  logic [DW-1:0] mMem [N];
  bit          mKnown [N];
  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit acc, hs, nLo, nHi;
    int half;
    if (!rstN) begin
      mPtr = 0; mStale[0] = 1; mStale[1] = 1; mInit = 1; mKick = 1;
      mErr = 0; mIrqI = 0; mIrqL = 0; mIrqH = 0;
      return;
    end
    acc  = advance && !mInit;
    half = (mPtr < N/2) ? 0 : 1;
    hs   = mStale[half];
    mIrqL = acc && (mPtr == N/2 - 1);
    mIrqH = acc && (mPtr == N - 1);
    if (acc && hs) mErr = 1; else if (hostErrClr) mErr = 0;
    nLo = mStale[0]; nHi = mStale[1];
    if (hostRestart || mIrqL) nLo = 1;
    else if (hostWrEn && hostWrAddr == IW'(N/2 - 1)) nLo = 0;
    if (hostRestart || mIrqH) nHi = 1;
    else if (hostWrEn && hostWrAddr == IW'(N - 1)) nHi = 0;
    mStale[0] = nLo; mStale[1] = nHi;
    mIrqI = mKick || hostRestart;
    mKick = 0;
    if (hostRestart || (frameStart && !mInit)) mPtr = 0;
    else if (acc) mPtr = (mPtr + 1) % N;
    if (hostRestart) mInit = 1;
    else if (mInit && !nLo && !nHi) mInit = 0;
    if (hostWrEn) begin
      mMem[hostWrAddr] = hostWrData;
      mKnown[hostWrAddr] = 1;
    end
  endtask

  task automatic compareAll();
    chk("R7", "tableReady", tableReady, !mInit);
    chk("R2", "rdIdx", rdIdx, mPtr);
    if (mKnown[mPtr]) chk("R1", "rdData", rdData, mMem[mPtr]);
    chk("R6", "irqInit", irqInit, mIrqI);
    chk("R3", "irqRenewLo", irqRenewLo, mIrqL);
    chk("R4", "irqRenewHi", irqRenewHi, mIrqH);
    chk("R8", "underrunErr", underrunErr, mErr);
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
    compareAll();
  endtask

  task automatic idle();
    hostWrEn = 0; hostRestart = 0; hostErrClr = 0; frameStart = 0; advance = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int gen);
    return DW'((i * 32'h00010307) ^ (gen * 32'h005A3C1) ^ 32'h00A5A5);
  endfunction

  task automatic advN(input int n);
    for (int k = 0; k < n; k++) begin
      advance = 1; tick();
    end
    advance = 0;
  endtask

  task automatic writeRange(input int lo, input int hi, input int gen);
    for (int a = lo; a <= hi; a++) begin
      hostWrEn = 1; hostWrAddr = IW'(a); hostWrData = pat(a, gen); tick();
    end
    hostWrEn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hAddr;
    for (int i = 0; i < N; i++) mKnown[i] = 0;
    idle();
    repeat (3) tick();
    chk("R6", "reset irqInit", irqInit, 0);
    chk("R7", "reset tableReady", tableReady, 0);
    rstN = 1;
    tick();
    chk("R6", "irqInit after reset", irqInit, 1);
    tick();
    chk("R6", "irqInit single pulse", irqInit, 0);

    // advance and frameStart have no effect before loading
    advance = 1; frameStart = 1; tick(); idle();
    chk("R7", "pointer held during init", rdIdx, 0);

    // only the lower half loaded: still not ready
    writeRange(0, 127, 0);
    tick();
    chk("R7", "not ready with upper stale", tableReady, 0);
    writeRange(128, 254, 0);
    tick();
    chk("R5", "non-last write keeps upper stale", tableReady, 0);
    writeRange(255, 255, 0);
    tick();
    chk("R7", "ready after both halves loaded", tableReady, 1);
    chk("R1", "entry 0 visible", rdData, pat(0, 0));

    advN(127);
    chk("R2", "pointer at 127", rdIdx, 127);
    // same cycle: consume 127 and host refreshes entry 127
    advance = 1; hostWrEn = 1; hostWrAddr = IW'(127); hostWrData = pat(127, 1);
    tick(); idle();
    chk("R3", "renew lower pulse", irqRenewLo, 1);
    tick();
    chk("R3", "renew lower one cycle", irqRenewLo, 0);

    advN(127);
    chk("R2", "pointer at 255", rdIdx, 255);
    advance = 1; tick(); idle();
    chk("R4", "renew upper pulse", irqRenewHi, 1);
    chk("R2", "wrap to 0", rdIdx, 0);
    // lower half was flagged in the same cycle as its refill: still stale
    advance = 1; tick(); idle();
    chk("R5", "set wins over refill", underrunErr, 1);
    tick();
    chk("R8", "underrun sticky", underrunErr, 1);
    // clear in same cycle as a new underrun: stays set
    advance = 1; hostErrClr = 1; tick(); idle();
    chk("R8", "new underrun beats clear", underrunErr, 1);
    hostErrClr = 1; tick(); idle();
    chk("R8", "host clear", underrunErr, 0);

    // refresh lower, then advancing in lower is clean
    writeRange(0, 127, 2);
    advance = 1; tick(); idle();
    chk("R5", "refilled half gives no underrun", underrunErr, 0);

    // frameStart overrides advance
    advance = 1; frameStart = 1; tick(); idle();
    chk("R9", "frame start rewinds", rdIdx, 0);
    chk("R1", "entry 0 new record", rdData, pat(0, 2));

    // restart
    hostRestart = 1; tick(); idle();
    chk("R6", "irqInit after restart", irqInit, 1);
    chk("R6", "restart drops ready", tableReady, 0);
    writeRange(0, 255, 3);
    tick();
    chk("R7", "ready after reload", tableReady, 1);

    // random phase, compared every cycle
    hAddr = 0;
    for (int c = 0; c < 6000; c++) begin
      idle();
      advance    = ($urandom_range(0, 2) != 0);
      frameStart = ($urandom_range(0, 499) == 0);
      hostErrClr = ($urandom_range(0, 63) == 0);
      hostRestart = ($urandom_range(0, 2999) == 0);
      if ($urandom_range(0, 1) == 0) begin
        hostWrEn = 1; hostWrAddr = IW'(hAddr); hostWrData = DW'($urandom);
        hAddr = (hAddr + 1) % N;
      end
      tick();
    end
    idle();
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule